// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This controller connects a host port with a valid/ready handshake to a 16384-byte dynamic memory. The memory is organised as 128 rows by 128 columns. Each host request carries a 14-bit byte address, a write flag and one data byte. The controller splits the address into two 7-bit halves and sends them over one shared address bus. The row half goes out first with an active-low row strobe. The column half follows with an active-low column strobe. During the column phase the controller drives the write-enable line low for writes. For reads it captures the byte the memory returns.

The cells lose their charge over time, and every read discharges them. For that reason the row strobe stays low for the whole access, so the memory can write the sensed row back. Refresh runs on a free-running interval timer, which raises a refresh request at fixed intervals. A 7-bit counter steps through all rows in turn. Refresh is a row-only cycle in which the column strobe stays high. After every cycle of either kind, both strobes return high for a fixed precharge time.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The row address is `req_addr[6:0]` and the column address is `req_addr[13:7]`. Both go out on `mem_addr[6:0]`: the row while only the row strobe is low, the column while both strobes are low.
- R2: An access begins the cycle after the handshake. `mem_ras_n` is low and `mem_cas_n` is high for `T_RCD` cycles. Then both strobes are low for `T_CAS` cycles with the column held steady on `mem_addr`. `mem_ras_n` stays low until the column phase ends.
- R3: `mem_cas_n` is low only while `mem_ras_n` is low, and it falls only when `mem_ras_n` was already low in the cycle before.
- R4: For a write (`req_write`=1), `mem_we_n` is low during the column phase and `mem_din` carries the request byte. At all other times `mem_we_n` is high.
- R5: For a read, `rd_valid` pulses high for exactly one cycle, in the cycle after the last column-phase cycle. `rd_data` then holds the byte `mem_dout` carried in that last column-phase cycle.
- R6: A refresh request is raised every `REF_INTERVAL` cycles, counted from reset release. A refresh cycle puts the refresh row on `mem_addr` and holds `mem_ras_n` low for `T_RFC` cycles. `mem_cas_n` stays high throughout.
- R7: The refresh row is 0 for the first refresh after reset. It advances by one per refresh and wraps from 127 to 0.
- R8: When a refresh is pending and the controller is idle, the refresh starts next, even if a host request is waiting. An access already under way runs to completion before the refresh.
- R9: After every access or refresh, both strobes are high for `T_RP` cycles, and `req_ready` is low during that time.
- R10: `req_ready` is high only when the controller is idle and no refresh is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R11: While in reset, both strobes and `mem_we_n` are high and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Linear byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read return strobe |
| rd_data | output | 8 | Read byte |
| mem_addr | output | 7 | Shared row/column address bus |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_din | output | 8 | Byte written to the memory |
| mem_dout | input | 8 | Byte read from the memory |

## Verification
The two functions that can collide are a refresh becoming due and a host request waiting at the same idle cycle. The bench provokes this by keeping `req_valid` asserted across long runs of back-to-back random requests. Refresh deadlines therefore land inside accesses, inside precharge and on the idle cycle itself. A behavioural model with an expected-waveform queue decides, cycle by cycle, whether refresh or the host access owns the bus. It compares strobes, address, write enable, ready and read data on every clock, so a grant in the wrong order shows up as a strobe or address mismatch.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_REF  = 3'd3,
    ST_PRE  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W    = 7,
  parameter int INTERVAL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_start,
  input  logic             ref_done,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(INTERVAL - 1);

  logic [TW-1:0]    tmr_q, tmr_d;
  logic             pend_d;
  logic [ROW_W-1:0] row_d;
  logic             tick;

  always_comb begin
    tick   = (tmr_q == T_LAST);
    tmr_d  = tick ? '0 : tmr_q + TW'(1);
    pend_d = tick | (ref_pending & ~ref_start);
    row_d  = ref_done ? ref_row + ROW_W'(1) : ref_row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q       <= '0;
      ref_pending <= 1'b0;
      ref_row     <= '0;
    end else begin
      tmr_q       <= tmr_d;
      ref_pending <= pend_d;
      ref_row     <= row_d;
    end
  end

  // R7: the row after the last one is row zero
  assert_row_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ref_done) && ($past(ref_row) == {ROW_W{1'b1}})) |-> (ref_row == '0));

  // R6: a granted refresh clears the request unless a new tick arrived
  assert_pending_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_start && !tick) |=> !ref_pending);
endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 7,
  parameter int COL_W  = 7,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RFC  = 3,
  parameter int T_RP   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_ready,
  input  logic                    ref_pending,
  input  logic [ROW_W-1:0]        ref_row,
  output logic                    ref_start,
  output logic                    ref_done,
  output logic [ROW_W-1:0]        mem_addr,
  output logic                    mem_ras_n,
  output logic                    mem_cas_n,
  output logic                    mem_we_n,
  output logic [DATA_W-1:0]       mem_din,
  input  logic [DATA_W-1:0]       mem_dout,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int TMAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TMAX_B = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int CW     = (TMAX > 1) ? $clog2(TMAX) : 1;

  seq_state_t        st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cap_en, rd_cap, last;

  assign req_ready = (st_q == ST_IDLE) && !ref_pending;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cap_en    = 1'b0;
    rd_cap    = 1'b0;
    ref_start = 1'b0;
    ref_done  = 1'b0;
    last      = (cnt_q == '0);
    case (st_q)
      ST_IDLE: begin
        if (ref_pending) begin
          st_d      = ST_REF;
          cnt_d     = CW'(T_RFC - 1);
          ref_start = 1'b1;
        end else if (req_valid) begin
          st_d   = ST_ROW;
          cnt_d  = CW'(T_RCD - 1);
          cap_en = 1'b1;
        end
      end
      ST_ROW: begin
        if (last) begin
          st_d  = ST_COL;
          cnt_d = CW'(T_CAS - 1);
        end else cnt_d = cnt_q - CW'(1);
      end
      ST_COL: begin
        if (last) begin
          st_d   = ST_PRE;
          cnt_d  = CW'(T_RP - 1);
          rd_cap = !wr_q;
        end else cnt_d = cnt_q - CW'(1);
      end
      ST_REF: begin
        if (last) begin
          st_d     = ST_PRE;
          cnt_d    = CW'(T_RP - 1);
          ref_done = 1'b1;
        end else cnt_d = cnt_q - CW'(1);
      end
      ST_PRE: begin
        if (last) st_d = ST_IDLE;
        else      cnt_d = cnt_q - CW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      rd_valid <= rd_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (cap_en) begin
      row_q   <= req_addr[ROW_W-1:0];
      col_q   <= req_addr[ADDR_W-1:ROW_W];
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_cap) rd_data <= mem_dout;
  end

  always_comb begin
    mem_ras_n = !((st_q == ST_ROW) || (st_q == ST_COL) || (st_q == ST_REF));
    mem_cas_n = (st_q != ST_COL);
    mem_we_n  = !((st_q == ST_COL) && wr_q);
    mem_din   = wdata_q;
    if (st_q == ST_COL)      mem_addr = col_q;
    else if (st_q == ST_REF) mem_addr = ref_row;
    else                     mem_addr = row_q;
  end

  assert_cas_inside_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cas_n |-> !mem_ras_n);
  assert_cas_after_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> $past(!mem_ras_n));
  assert_col_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cas_n && $past(!mem_cas_n)) |-> $stable(mem_addr));
  assert_we_in_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cas_n);
  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_pre_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ras_n) |-> !req_ready);
  assert_refresh_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pending && mem_ras_n && req_valid && (st_q == ST_IDLE)) |=> (!mem_ras_n && mem_cas_n));
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W        = 7,
  parameter int COL_W        = 7,
  parameter int DATA_W       = 8,
  parameter int REF_INTERVAL = 64,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RFC        = 3,
  parameter int T_RP         = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic [ROW_W-1:0]       mem_addr,
  output logic                   mem_ras_n,
  output logic                   mem_cas_n,
  output logic                   mem_we_n,
  output logic [DATA_W-1:0]      mem_din,
  input  logic [DATA_W-1:0]      mem_dout
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             ref_start, ref_done, ref_pending;
  logic [ROW_W-1:0] ref_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dram_refresh_sched #(
    .ROW_W(ROW_W), .INTERVAL(REF_INTERVAL)
  ) u_sched (
    .clk(clk), .rst_n(rst_int_n),
    .ref_start(ref_start), .ref_done(ref_done),
    .ref_pending(ref_pending), .ref_row(ref_row)
  );

  dram_access_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RFC(T_RFC), .T_RP(T_RP)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ref_pending(ref_pending), .ref_row(ref_row),
    .ref_start(ref_start), .ref_done(ref_done),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_din(mem_din), .mem_dout(mem_dout),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: tb/dram_mux_ctrl_tb_top.sv
module dram_mux_ctrl_tb_top;
  localparam int INTV  = 64;
  localparam int T_RCD = 2;
  localparam int T_CAS = 2;
  localparam int T_RFC = 3;
  localparam int T_RP  = 2;
  localparam int DEPTH = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, mem_ras_n, mem_cas_n, mem_we_n;
  logic [7:0]  rd_data, mem_din, mem_dout;
  logic [6:0]  mem_addr;

  always #2 clk = ~clk;

  dram_mux_ctrl #(
    .REF_INTERVAL(INTV), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RFC(T_RFC), .T_RP(T_RP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_din(mem_din), .mem_dout(mem_dout)
  );

  // ---------------- behavioural memory device ----------------
  logic [7:0] arr [DEPTH];
  logic [6:0] row_l = '0, col_l = '0;
  bit         ras_act = 0, cas_act = 0;
  assign mem_dout = arr[{col_l, row_l}];

  always @(negedge clk) begin
    if (mem_ras_n) begin
      ras_act = 0; cas_act = 0;
    end else if (!ras_act) begin
      ras_act = 1; row_l = mem_addr;
    end else if (!mem_cas_n && !cas_act) begin
      cas_act = 1; col_l = mem_addr;
    end
    if (cas_act && !mem_we_n) arr[{col_l, row_l}] = mem_din;
  end

  // ---------------- reference model ----------------
  typedef struct packed {
    logic       ras_n, cas_n, we_n;
    logic [6:0] addr;
    logic       chk_addr;
    logic       chk_din;
    logic [7:0] din;
    logic       rdv;
    logic [7:0] rdat;
    logic [2:0] kind; // 1 row, 2 col, 3 refresh, 4 precharge
  } word_t;

  word_t      plan[$];
  logic [7:0] shadow [DEPTH];
  int         since = 0, tmr = 0, ref_row = 0, n_ref = 0;
  bit         pend = 0;
  int         n_cmp = 0, n_bad = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [2:0] k);
    case (k)
      3'd1: return "R1 R2";
      3'd2: return "R1 R2 R4";
      3'd3: return "R6 R7 R8";
      3'd4: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(negedge clk) begin
    word_t cur;
    bit empty, start, nxt;
    string tg;
    if (!rst_n) since = 0;
    else if (since < 3) since++;
    if (since < 3) begin
      plan.delete(); tmr = 0; pend = 0; ref_row = 0;
      chk(mem_ras_n && mem_cas_n && mem_we_n, "R11", "strobes in reset",
          {mem_ras_n, mem_cas_n, mem_we_n}, 3'b111);
      chk(!rd_valid, "R11", "rd_valid in reset", rd_valid, 0);
    end else begin
      empty = (plan.size() == 0);
      if (empty) cur = '{ras_n:1, cas_n:1, we_n:1, default:'0};
      else       cur = plan[0];
      tg = tag_of(cur.kind);
      chk(mem_ras_n == cur.ras_n, tg, "mem_ras_n", mem_ras_n, cur.ras_n);
      chk(mem_cas_n == cur.cas_n, tg, "mem_cas_n", mem_cas_n, cur.cas_n);
      chk(mem_we_n == cur.we_n, "R4", "mem_we_n", mem_we_n, cur.we_n);
      if (cur.chk_addr) chk(mem_addr == cur.addr, tg, "mem_addr", mem_addr, cur.addr);
      if (cur.chk_din)  chk(mem_din == cur.din, "R4", "mem_din", mem_din, cur.din);
      chk(rd_valid == cur.rdv, "R5", "rd_valid", rd_valid, cur.rdv);
      if (cur.rdv) chk(rd_data == cur.rdat, "R5", "rd_data", rd_data, cur.rdat);
      chk(req_ready == (empty && !pend), empty ? "R10" : "R9", "req_ready",
          req_ready, empty && !pend);
      chk(!(!mem_cas_n && mem_ras_n), "R3", "cas without ras", mem_cas_n, 1);
      start = 0;
      if (empty) begin
        if (pend) begin
          start = 1;
          for (int i = 0; i < T_RFC; i++)
            plan.push_back('{ras_n:0, cas_n:1, we_n:1, addr:7'(ref_row), chk_addr:1, kind:3, default:'0});
          for (int i = 0; i < T_RP; i++)
            plan.push_back('{ras_n:1, cas_n:1, we_n:1, kind:4, default:'0});
          ref_row = (ref_row + 1) % 128;
          n_ref++;
        end else if (req_valid) begin
          for (int i = 0; i < T_RCD; i++)
            plan.push_back('{ras_n:0, cas_n:1, we_n:1, addr:req_addr[6:0], chk_addr:1, kind:1, default:'0});
          for (int i = 0; i < T_CAS; i++)
            plan.push_back('{ras_n:0, cas_n:0, we_n:!req_write, addr:req_addr[13:7], chk_addr:1,
                             chk_din:req_write, din:req_wdata, kind:2, default:'0});
          for (int i = 0; i < T_RP; i++)
            plan.push_back('{ras_n:1, cas_n:1, we_n:1, rdv:(i == 0) && !req_write,
                             rdat:shadow[req_addr], kind:4, default:'0});
          if (req_write) shadow[req_addr] = req_wdata;
        end
      end else void'(plan.pop_front());
      nxt  = (tmr == INTV - 1) || (pend && !start);
      tmr  = (tmr == INTV - 1) ? 0 : tmr + 1;
      pend = nxt;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(bit w, logic [13:0] a, logic [7:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) begin
        @(posedge clk); #1;
        break;
      end
    end
  endtask

  task automatic drop();
    req_valid = 0;
  endtask

  logic [13:0] corners [6] = '{14'd0, 14'd127, 14'd128, 14'd16383, 14'h2AAA, 14'h1555};

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      arr[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (10) @(posedge clk); #1;
    // R1 R4: writes at address corners, gaps between them
    foreach (corners[i]) begin
      issue(1, corners[i], 8'hA0 + 8'(i));
      drop();
      repeat (3) @(posedge clk); #1;
    end
    // R1 R5: read back, then read never-written cells
    foreach (corners[i]) begin issue(0, corners[i], 8'h00); drop(); end
    issue(0, 14'd5000, 8'h00); drop();
    // R6 R7: refresh-only stretch
    repeat (400) @(posedge clk); #1;
    // R8: requests held back to back so refresh deadlines collide with them
    for (int n = 0; n < 2500; n++) begin
      logic [13:0] a;
      a = (n % 4 == 0) ? corners[n % 6] : 14'($urandom);
      issue(1'($urandom), a, 8'($urandom));
    end
    drop();
    repeat (200) @(posedge clk);
    @(negedge clk);
    // R7: enough refreshes to wrap the row counter
    chk(n_ref > 128, "R7", "refresh count beyond wrap", n_ref, 129);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule